// File: doc/BRIEF.md
# Lockable Round-Robin TLB

A fully associative translation cache of 32 entries. Every entry holds a virtual page number, a physical page number, a small attribute field, a valid bit and a lock bit. A lookup compares the presented virtual page number against all valid entries in the same cycle. It returns a hit flag, the physical page number and the attributes. It also raises a separate flag when more than one entry matches.

Entries are written by two kinds of fill, and both take data from one shared write port.

- A normal fill is used after a miss. It goes to the slot under a round-robin pointer. That pointer steps through the entries that are not locked and wraps from the top entry back to the first unlocked slot.
- A lock fill places a translation at a lock pointer that grows a pinned region upward from entry 0. Pinned entries are never chosen for replacement. The top entry can never be pinned: a lock fill aimed at it becomes an ordinary write there, and both pointers stay parked on that entry.

Maintenance commands are also provided:

- Invalidate everything.
- Invalidate one entry by index.
- Release all pins without discarding the translations.

Top module: `lrr_tlb`

## Requirements
- R1: After reset no entry is valid, both pointers are at entry 0, and every lookup misses with the multi-match flag low.
- R2: A lookup hits, in the same cycle, when a valid entry holds the presented virtual page number. It then returns that entry's physical page number and attributes; these outputs are defined only when exactly one entry matches. When two or more valid entries match, the multi-match flag is raised together with the hit flag.
- R3: A normal fill writes the entry under the round-robin pointer, marks it valid and unlocked, and advances the pointer by one. From the top entry (index 31) the pointer wraps to the current lock pointer.
- R4: A lock fill, with the lock pointer below 31, writes the entry under the lock pointer, marks it valid and locked, and increments the lock pointer. If the round-robin pointer was not above the old lock pointer, it moves to the new lock pointer.
- R5: A lock fill while the lock pointer is at 31 writes entry 31 as valid and unlocked and leaves both pointers at 31. Every later normal fill then also writes entry 31.
- R6: Locked entries are never overwritten by normal fills, however many fills occur.
- R7: A global invalidate clears every valid bit and leaves the lock bits and the lock pointer as they were, so later normal fills still skip the locked region.
- R8: A single-entry invalidate clears only the valid bit of the entry at the given index.
- R9: A global unlock clears every lock bit and resets the lock pointer to 0, while the entries stay valid and still hit.
- R10: Only one command acts per cycle, chosen in this priority order: global invalidate, single invalidate, global unlock, lock fill, normal fill.
- R11: A lookup in the same cycle as a command sees the contents as they stood before that command. The command's effect is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_hit | output | 1 | Some valid entry matches lk_vpn |
| lk_multi | output | 1 | Two or more valid entries match lk_vpn |
| lk_ppn | output | PPN_W | Physical page number of the matching entry |
| lk_attr | output | ATTR_W | Attribute field of the matching entry |
| wr_vpn | input | VPN_W | Virtual page number for a fill |
| wr_ppn | input | PPN_W | Physical page number for a fill |
| wr_attr | input | ATTR_W | Attributes for a fill |
| fill_req | input | 1 | Normal fill at the round-robin slot |
| lock_req | input | 1 | Fill and pin at the lock pointer |
| inv_all_req | input | 1 | Clear all valid bits |
| inv_one_req | input | 1 | Clear the valid bit of entry inv_idx |
| inv_idx | input | IDX_W | Entry index for the single invalidate |
| unlock_req | input | 1 | Release all pins, lock pointer to 0 |

## Verification
Two functions can fall in the same cycle.

- **Lookup during a write.** A lookup may coincide with a fill that writes the very page it asks for. The bench drives the fill and a lookup of the same page before one edge. It expects a miss before the edge and a hit with the new data after it.
- **Competing commands.** Several commands may be requested together. The bench raises all request lines at once, and separately a lock fill together with a normal fill. It then probes which page landed and which entries survived, against a reference model that applies only the winning command.

Random traffic over a small page space repeats these collisions and produces multi-matches. The model predicts every lookup result.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE    = 3'd0,
      CMD_INV_ALL = 3'd1,
      CMD_INV_ONE = 3'd2,
      CMD_UNLOCK  = 3'd3,
      CMD_LOCK    = 3'd4,
      CMD_FILL    = 3'd5
   } tlb_cmd_e;

   // one command per cycle, highest priority first
   function automatic tlb_cmd_e pick_cmd(input logic inv_all, input logic inv_one,
                                         input logic unlock, input logic lock,
                                         input logic fill);
      if (inv_all)      return CMD_INV_ALL;
      else if (inv_one) return CMD_INV_ONE;
      else if (unlock)  return CMD_UNLOCK;
      else if (lock)    return CMD_LOCK;
      else if (fill)    return CMD_FILL;
      else              return CMD_IDLE;
   endfunction

endpackage

// File: rtl/tlb_ptr_ctrl.sv
module tlb_ptr_ctrl
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 32,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tlb_cmd_e         cmd,
   output logic [IDX_W-1:0] lock_ptr,
   output logic [IDX_W-1:0] rr_ptr,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             wr_lock
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] lock_ptr_n, rr_ptr_n;
   logic             lock_full;

   assign lock_full = (lock_ptr == LAST_IDX);

   // write slot selection
   always_comb begin
      wr_en   = 1'b0;
      wr_idx  = rr_ptr;
      wr_lock = 1'b0;
      unique case (cmd)
         CMD_LOCK: begin
            wr_en   = 1'b1;
            wr_idx  = lock_full ? LAST_IDX : lock_ptr;
            wr_lock = !lock_full;
         end
         CMD_FILL: begin
            wr_en   = 1'b1;
            wr_idx  = rr_ptr;
         end
         default: ;
      endcase
   end

   // pointer update
   always_comb begin
      lock_ptr_n = lock_ptr;
      rr_ptr_n   = rr_ptr;
      unique case (cmd)
         CMD_UNLOCK: lock_ptr_n = '0;
         CMD_LOCK: begin
            if (!lock_full) begin
               lock_ptr_n = lock_ptr + IDX_W'(1);
               if (rr_ptr <= lock_ptr) rr_ptr_n = lock_ptr + IDX_W'(1);
            end
         end
         CMD_FILL: rr_ptr_n = (rr_ptr == LAST_IDX) ? lock_ptr : rr_ptr + IDX_W'(1);
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_ptr <= '0;
         rr_ptr   <= '0;
      end else begin
         lock_ptr <= lock_ptr_n;
         rr_ptr   <= rr_ptr_n;
      end
   end

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 20,
   parameter int DATA_W  = 24,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  tlb_cmd_e                       cmd,
   input  logic [IDX_W-1:0]               inv_idx,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic                           wr_lock,
   input  logic [VPN_W-1:0]               wr_vpn,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [VPN_W-1:0]               lk_vpn,
   output logic [ENTRIES-1:0]             match_vec,
   output logic [ENTRIES-1:0]             valid_vec,
   output logic [ENTRIES-1:0]             lock_vec,
   output logic [ENTRIES-1:0][DATA_W-1:0] data_arr
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic              sel;
      logic              v_q, l_q;
      logic [VPN_W-1:0]  tag_q;
      logic [DATA_W-1:0] dat_q;

      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            l_q <= 1'b0;
         end else begin
            if (cmd == CMD_INV_ALL)
               v_q <= 1'b0;
            else if (cmd == CMD_INV_ONE && inv_idx == IDX_W'(e))
               v_q <= 1'b0;
            else if (sel)
               v_q <= 1'b1;

            if (cmd == CMD_UNLOCK)
               l_q <= 1'b0;
            else if (sel)
               l_q <= wr_lock;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q <= wr_vpn;
            dat_q <= wr_data;
         end
      end

      assign match_vec[e] = v_q && (tag_q == lk_vpn);
      assign valid_vec[e] = v_q;
      assign lock_vec[e]  = l_q;
      assign data_arr[e]  = dat_q;
   end

endmodule

// File: rtl/tlb_hit_merge.sv
module tlb_hit_merge #(
   parameter int ENTRIES = 32,
   parameter int DATA_W  = 24
) (
   input  logic [ENTRIES-1:0]             match_vec,
   input  logic [ENTRIES-1:0][DATA_W-1:0] data_arr,
   output logic                           hit,
   output logic                           multi,
   output logic [DATA_W-1:0]              data
);

   always_comb begin
      hit   = 1'b0;
      multi = 1'b0;
      data  = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match_vec[e]) begin
            if (hit) multi = 1'b1;
            hit  = 1'b1;
            data = data | data_arr[e];
         end
      end
   end

endmodule

// File: rtl/lrr_tlb.sv
module lrr_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ATTR_W  = 4,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              lk_hit,
   output logic              lk_multi,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [ATTR_W-1:0] lk_attr,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [ATTR_W-1:0] wr_attr,
   input  logic              fill_req,
   input  logic              lock_req,
   input  logic              inv_all_req,
   input  logic              inv_one_req,
   input  logic [IDX_W-1:0]  inv_idx,
   input  logic              unlock_req
);

   localparam int DATA_W = PPN_W + ATTR_W;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("lrr_tlb: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || ATTR_W < 1) begin : g_bad_width
      $error("lrr_tlb: field widths must be at least 1");
   end

   tlb_cmd_e                       cmd;
   logic [IDX_W-1:0]               lock_ptr, rr_ptr, wr_idx;
   logic                           wr_en, wr_lock;
   logic [ENTRIES-1:0]             match_vec, valid_vec, lock_vec;
   logic [ENTRIES-1:0][DATA_W-1:0] data_arr;
   logic [DATA_W-1:0]              hit_data;

   assign cmd = pick_cmd(inv_all_req, inv_one_req, unlock_req, lock_req, fill_req);

   tlb_ptr_ctrl #(.ENTRIES(ENTRIES)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .lock_ptr (lock_ptr),
      .rr_ptr   (rr_ptr),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_lock  (wr_lock)
   );

   tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .DATA_W(DATA_W)) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .inv_idx   (inv_idx),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_lock   (wr_lock),
      .wr_vpn    (wr_vpn),
      .wr_data   ({wr_ppn, wr_attr}),
      .lk_vpn    (lk_vpn),
      .match_vec (match_vec),
      .valid_vec (valid_vec),
      .lock_vec  (lock_vec),
      .data_arr  (data_arr)
   );

   tlb_hit_merge #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_merge (
      .match_vec (match_vec),
      .data_arr  (data_arr),
      .hit       (lk_hit),
      .multi     (lk_multi),
      .data      (hit_data)
   );

   assign lk_ppn  = hit_data[DATA_W-1:ATTR_W];
   assign lk_attr = hit_data[ATTR_W-1:0];

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 32,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input tlb_cmd_e           cmd,
   input logic [IDX_W-1:0]   lock_ptr,
   input logic [IDX_W-1:0]   rr_ptr,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [ENTRIES-1:0] lock_vec,
   input logic               lk_hit,
   input logic               lk_multi
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   logic [ENTRIES-1:0] prefix_mask;
   always_comb begin
      for (int e = 0; e < ENTRIES; e++) prefix_mask[e] = (e < int'(lock_ptr));
   end

   AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_multi |-> lk_hit);                                                  // R2
   AST_FILL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_FILL && rr_ptr == LAST_IDX) |=> rr_ptr == $past(lock_ptr)); // R3
   AST_RR_NOT_BELOW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rr_ptr >= lock_ptr);                                                   // R4
   AST_LOCK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      lock_vec == prefix_mask);                                              // R4
   AST_LAST_NEVER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_vec[ENTRIES-1]);                                                 // R5
   AST_LOCK_AT_LAST_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_LOCK && lock_ptr == LAST_IDX) |=> (lock_ptr == LAST_IDX && rr_ptr == LAST_IDX)); // R5
   AST_FILL_KEEPS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_FILL) |=> $stable(lock_vec));                              // R6
   AST_INV_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_INV_ALL) |=> (valid_vec == '0 && $stable(lock_vec)));      // R7
   AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_UNLOCK) |=> (lock_ptr == '0 && lock_vec == '0 && $stable(valid_vec))); // R9

endmodule

bind lrr_tlb tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd       (cmd),
   .lock_ptr  (lock_ptr),
   .rr_ptr    (rr_ptr),
   .valid_vec (valid_vec),
   .lock_vec  (lock_vec),
   .lk_hit    (lk_hit),
   .lk_multi  (lk_multi)
);

// File: tb/tb_lrr_tlb.sv
module tb_lrr_tlb;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 32;
   localparam int VW = 20;
   localparam int PW = 20;
   localparam int AW = 4;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic          lk_hit, lk_multi;
   logic [PW-1:0] lk_ppn;
   logic [AW-1:0] lk_attr;
   logic [VW-1:0] wr_vpn = '0;
   logic [PW-1:0] wr_ppn = '0;
   logic [AW-1:0] wr_attr = '0;
   logic          fill_req = 0, lock_req = 0, inv_all_req = 0, inv_one_req = 0, unlock_req = 0;
   logic [IW-1:0] inv_idx = '0;

   lrr_tlb #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW), .ATTR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_multi(lk_multi),
      .lk_ppn(lk_ppn), .lk_attr(lk_attr), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
      .wr_attr(wr_attr), .fill_req(fill_req), .lock_req(lock_req),
      .inv_all_req(inv_all_req), .inv_one_req(inv_one_req), .inv_idx(inv_idx),
      .unlock_req(unlock_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   // reference model
   logic [VW-1:0] m_vpn [N];
   logic [PW-1:0] m_ppn [N];
   logic [AW-1:0] m_attr[N];
   bit            m_val [N];
   bit            m_lck [N];
   int            m_lp = 0;
   int            m_rr = 0;

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic m_write(input int slot, input int v, input int p, input int a, input bit lk);
      m_vpn[slot]  = VW'(v);
      m_ppn[slot]  = PW'(p);
      m_attr[slot] = AW'(a);
      m_val[slot]  = 1'b1;
      m_lck[slot]  = lk;
   endtask

   task automatic m_apply(input bit ia, input bit io, input int idx, input bit ul,
                          input bit lk, input bit fl, input int v, input int p, input int a);
      if (ia) begin
         for (int e = 0; e < N; e++) m_val[e] = 1'b0;
      end else if (io) begin
         m_val[idx] = 1'b0;
      end else if (ul) begin
         for (int e = 0; e < N; e++) m_lck[e] = 1'b0;
         m_lp = 0;
      end else if (lk) begin
         if (m_lp == N-1) m_write(N-1, v, p, a, 1'b0);
         else begin
            m_write(m_lp, v, p, a, 1'b1);
            if (m_rr <= m_lp) m_rr = m_lp + 1;
            m_lp = m_lp + 1;
         end
      end else if (fl) begin
         m_write(m_rr, v, p, a, 1'b0);
         m_rr = (m_rr == N-1) ? m_lp : m_rr + 1;
      end
   endtask

   task automatic do_cmd(input bit ia, input bit io, input int idx, input bit ul,
                         input bit lk, input bit fl, input int v, input int p, input int a);
      @(negedge clk);
      inv_all_req = ia; inv_one_req = io; inv_idx = IW'(idx); unlock_req = ul;
      lock_req = lk; fill_req = fl;
      wr_vpn = VW'(v); wr_ppn = PW'(p); wr_attr = AW'(a);
      @(negedge clk);
      inv_all_req = 0; inv_one_req = 0; unlock_req = 0; lock_req = 0; fill_req = 0;
      m_apply(ia, io, idx, ul, lk, fl, v, p, a);
   endtask

   task automatic fill(input int v, input int p, input int a);
      do_cmd(0, 0, 0, 0, 0, 1, v, p, a);
   endtask

   task automatic lockf(input int v, input int p, input int a);
      do_cmd(0, 0, 0, 0, 1, 0, v, p, a);
   endtask

   // lookup compared with model
   task automatic probe(input int v, input string tag);
      int  cnt = 0;
      int  slot = 0;
      lk_vpn = VW'(v);
      #1;
      for (int e = 0; e < N; e++)
         if (m_val[e] && m_vpn[e] == VW'(v)) begin cnt++; slot = e; end
      chk(tag, "hit", 32'(lk_hit), 32'(cnt > 0));
      chk(tag, "multi", 32'(lk_multi), 32'(cnt > 1));
      if (cnt == 1) begin
         chk(tag, "ppn", 32'(lk_ppn), 32'(m_ppn[slot]));
         chk(tag, "attr", 32'(lk_attr), 32'(m_attr[slot]));
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2718));
      for (int e = 0; e < N; e++) begin m_val[e] = 0; m_lck[e] = 0; m_vpn[e] = '0; end
      repeat (3) @(negedge clk);
      chk("R1", "hit in reset", 32'(lk_hit), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      probe(0, "R1");
      probe(5, "R1");

      // basic fills and lookups
      fill(10, 'h1_1111, 3);
      fill(11, 'h2_2222, 5);
      fill(12, 'h3_3333, 9);
      probe(10, "R2"); probe(11, "R2"); probe(12, "R2"); probe(13, "R2");

      // lookup during a fill of the same page
      @(negedge clk);
      fill_req = 1; wr_vpn = VW'(77); wr_ppn = PW'('hABCDE); wr_attr = 4'h7; lk_vpn = VW'(77);
      #1 chk("R11", "hit before edge", 32'(lk_hit), 32'd0);
      @(negedge clk);
      fill_req = 0;
      m_apply(0, 0, 0, 0, 0, 1, 77, 'hABCDE, 7);
      probe(77, "R11");

      // pin four entries
      for (int i = 0; i < 4; i++) lockf(100 + i, 'h10000 + i, i);
      for (int i = 0; i < 4; i++) probe(100 + i, "R4");
      // heavy replacement, pins must survive
      for (int i = 0; i < 40; i++) fill(200 + i, 'h20000 + i, i);
      for (int i = 0; i < 4; i++) probe(100 + i, "R6");
      for (int i = 0; i < 40; i++) probe(200 + i, "R3");

      // single invalidate, then global unlock
      do_cmd(0, 1, 2, 0, 0, 0, 0, 0, 0);
      probe(102, "R8"); probe(101, "R8"); probe(103, "R8");
      do_cmd(0, 0, 0, 1, 0, 0, 0, 0, 0);
      probe(100, "R9"); probe(101, "R9"); probe(103, "R9");

      // grow pinned region to the top entry
      for (int i = 0; i < 31; i++) lockf(300 + i, 'h30000 + i, i);
      probe(300, "R4"); probe(330, "R4");
      lockf(500, 'h50000, 1);
      probe(500, "R5");
      lockf(501, 'h50001, 2);
      probe(500, "R5"); probe(501, "R5");
      fill(600, 'h60000, 3);
      probe(501, "R5"); probe(600, "R5"); probe(315, "R5");

      // global invalidate keeps pins
      do_cmd(1, 0, 0, 0, 0, 0, 0, 0, 0);
      probe(300, "R7"); probe(600, "R7");
      fill(700, 'h70000, 4);
      fill(701, 'h70001, 5);
      probe(700, "R7"); probe(701, "R7");

      // priority between simultaneous commands
      do_cmd(0, 0, 0, 1, 0, 0, 0, 0, 0);
      fill(800, 'h80000, 6);
      do_cmd(0, 0, 0, 0, 1, 1, 810, 'h81000, 7);
      probe(810, "R10"); probe(800, "R10");
      do_cmd(1, 1, 0, 1, 1, 1, 820, 'h82000, 8);
      probe(810, "R10"); probe(820, "R10"); probe(800, "R10");

      // duplicate page gives multi-match
      fill(900, 'h90000, 1);
      fill(900, 'h90001, 2);
      probe(900, "R2");

      // constrained random traffic on a small page space
      for (int n = 0; n < 1500; n++) begin
         int    r = int'($urandom_range(99));
         int    v = int'($urandom_range(47));
         int    p = int'($urandom_range(20'hFFFFF));
         int    a = int'($urandom_range(15));
         int    ix = int'($urandom_range(N-1));
         string tg;
         if (r < 2)       begin do_cmd(1, 0, 0, 0, 0, 0, v, p, a); tg = "R7"; end
         else if (r < 8)  begin do_cmd(0, 1, ix, 0, 0, 0, v, p, a); tg = "R8"; end
         else if (r < 11) begin do_cmd(0, 0, 0, 1, 0, 0, v, p, a); tg = "R9"; end
         else if (r < 25) begin do_cmd(0, 0, 0, 0, 1, 0, v, p, a); tg = "R4"; end
         else if (r < 30) begin do_cmd(0, 0, 0, r[0], 1, 1, v, p, a); tg = "R10"; end
         else             begin do_cmd(0, 0, 0, 0, 0, 1, v, p, a); tg = "R3"; end
         probe(v, tg);
         for (int k = 0; k < 2; k++) probe(int'($urandom_range(47)), "R2");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule